// File: doc/BRIEF.md
# Order-Preserving Variable Cell Delay

This stage sits in a byte-serial stream of fixed 53-byte cells (five header bytes, then 48 payload bytes). Each clock carries one byte, with a strobe that marks the first byte of a cell and a flag that marks a cell as carrying no data. Cells arrive back to back, one per cell time. A header filter picks out the cells of chosen virtual connections. Each picked cell is held back by a number of cell times equal to the current state of a birth-death Markov chain. All other data cells go out as early as the output schedule allows. Slots that have nothing to carry are sent as generated idle cells.

The chain may only move when a cell that is not picked arrives. Empty cells count as not picked. On such an arrival, the chain compares a pseudorandom word against two thresholds taken from a writable per-state table. It then rises by one, falls by one, or stays where it is. Since the chain cannot move between two consecutive picked cells, a later picked cell always leaves at least one slot after an earlier one. Picked cells are therefore never reordered and never collide with each other. Loading the table from a target distribution is left to software.

Top module: `ordered_jitter`

## Requirements
- R1: After reset, and until the first input cell has been fully received, `out_start` is 0, `out_empty` is 1 and `out_data` is 0.
- R2: Input cells are numbered t = 0, 1, 2, … in arrival order. Output slot t is the cell sent while input cell t+1 arrives. Its byte k is registered on the same clock edge that samples byte k of input cell t+1. `out_start` is 1 on byte 0 of every slot and 0 on the other 52 bytes.
- R3: A cell is picked when `in_empty` is 0 and either `flt_all` is 1 or both masked compares agree. The VPI is byte0[3:0] followed by byte1[7:4]. The VCI is byte1[3:0], then byte2, then byte3[7:4]. A mask bit of 1 means that bit is compared.
- R4: A picked cell that arrives as cell t while the chain is in state i goes out unchanged in output slot t+i.
- R5: The chain starts in state 0 with the generator at `SEED`. On each arrival that is not picked (empty or not), let u and d be the thresholds of the current state and r the generator word. If r < u the state rises. Otherwise, if r < u+d, the state falls. Otherwise it holds. The state is clamped to the range 0 to `MAX_STATE`. After the comparison, the generator steps once: it shifts left with feedback bit r[15]^r[13]^r[12]^r[10]. A table write on `tbl_idx` affects every later arrival.
- R6: Non-empty cells that are not picked go out in arrival order. Each takes the earliest slot, counted from its arrival slot, that is not reserved for a picked cell.
- R7: When a picked cell is due in a slot, that slot carries it, and a waiting unpicked cell moves to a later slot.
- R8: A slot with no picked cell due and no unpicked cell waiting carries an idle cell: `out_empty` is 1 and the data is 0.
- R9: Every non-empty input cell appears exactly once at the output, and picked cells keep their arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Input cell byte |
| in_start | input | 1 | High on the first byte of each input cell |
| in_empty | input | 1 | High for the bytes of an empty input cell |
| flt_all | input | 1 | Pick every non-empty cell |
| flt_vpi | input | 8 | Path identifier to match |
| flt_vpi_mask | input | 8 | Compare mask for the path identifier |
| flt_vci | input | 16 | Channel identifier to match |
| flt_vci_mask | input | 16 | Compare mask for the channel identifier |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | ST_W | Chain state whose entry is written |
| tbl_up | input | PROB_W | Rise threshold |
| tbl_dn | input | PROB_W | Fall threshold |
| out_data | output | 8 | Output cell byte |
| out_start | output | 1 | High on byte 0 of each output slot |
| out_empty | output | 1 | High for idle output cells |

## Verification
In a single output slot, a picked cell can fall due at the same time as an unpicked cell is waiting in its queue. The bench provokes this in two ways. It drives a dense mix of picked, unpicked and empty cells, and it loads rise-heavy tables so that picked cells land on slots that unpicked cells would otherwise take. A behavioural model predicts, byte by byte, which cell each slot carries. Any slot where the picked cell did not win, or where the displaced cell did not reappear in order, shows up as a mismatch.

// File: rtl/ojit_pkg.sv
package ojit_pkg;
   localparam int CELL_BYTES = 53;
   localparam int HDR_CAPTURE = 4;
   localparam int IDX_W = $clog2(CELL_BYTES);

   typedef enum logic [1:0] {
      SRC_IDLE  = 2'd0,
      SRC_MATCH = 2'd1,
      SRC_PLAIN = 2'd2
   } src_e;

   typedef struct packed {
      logic [7:0]  vpi;
      logic [15:0] vci;
   } vc_addr_t;
endpackage

// File: rtl/ojit_hdr_filter.sv
module ojit_hdr_filter
   import ojit_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [IDX_W-1:0] pos,
   input  logic [7:0]       data,
   input  logic             void_in,
   input  logic             last,
   input  logic             sel_all,
   input  vc_addr_t         want,
   input  vc_addr_t         care,
   output logic             hit,
   output logic             is_void
);
   localparam logic [IDX_W-1:0] CAP_END = IDX_W'(HDR_CAPTURE);

   logic [31:0] hdr_q;
   logic        void_q;
   vc_addr_t    seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_q  <= '0;
         void_q <= 1'b1;
      end else if (en) begin
         if (pos < CAP_END) hdr_q <= {hdr_q[23:0], data};
         if (pos == '0)     void_q <= void_in;
      end
   end

   assign seen.vpi = hdr_q[27:20];
   assign seen.vci = hdr_q[19:4];
   assign is_void  = void_q;

   always_comb begin
      hit = 1'b0;
      if (!void_q) begin
         hit = sel_all || (((seen ^ want) & care) == '0);
      end
   end

   p_void_nomatch_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (last && is_void) |-> !hit);
endmodule

// File: rtl/ojit_chain.sv
module ojit_chain #(
   parameter int              MAX_STATE = 6,
   parameter int              PROB_W    = 16,
   parameter logic [PROB_W-1:0] SEED    = 'hACE1,
   localparam int             ST_W      = $clog2(MAX_STATE + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              tbl_we,
   input  logic [ST_W-1:0]   tbl_idx,
   input  logic [PROB_W-1:0] tbl_up,
   input  logic [PROB_W-1:0] tbl_dn,
   output logic [ST_W-1:0]   state
);
   localparam logic [ST_W-1:0] TOP = ST_W'(MAX_STATE);

   logic [PROB_W-1:0] up_tab [MAX_STATE+1];
   logic [PROB_W-1:0] dn_tab [MAX_STATE+1];
   logic [PROB_W-1:0] lfsr_q;
   logic              fb;
   logic [ST_W-1:0]   state_q, state_d;
   logic [PROB_W:0]   r_ext, lim_up, lim_dn;

   for (genvar g = 0; g <= MAX_STATE; g++) begin : g_ent
      logic [PROB_W-1:0] up_q, dn_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            up_q <= '0;
            dn_q <= '0;
         end else if (tbl_we && tbl_idx == ST_W'(g)) begin
            up_q <= tbl_up;
            dn_q <= tbl_dn;
         end
      end
      assign up_tab[g] = up_q;
      assign dn_tab[g] = dn_q;
   end

   if (PROB_W == 16) begin : g_taps16
      assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
   end else begin : g_taps24
      assign fb = lfsr_q[23] ^ lfsr_q[22] ^ lfsr_q[21] ^ lfsr_q[16];
   end

   initial begin : g_param_chk
      assert (PROB_W == 16 || PROB_W == 24) else $error("PROB_W must be 16 or 24");
      assert (SEED != '0) else $error("SEED must be nonzero");
   end

   assign r_ext  = {1'b0, lfsr_q};
   assign lim_up = {1'b0, up_tab[state_q]};
   assign lim_dn = lim_up + {1'b0, dn_tab[state_q]};

   always_comb begin
      state_d = state_q;
      if (step) begin
         if (r_ext < lim_up) begin
            if (state_q != TOP) state_d = state_q + ST_W'(1);
         end else if (r_ext < lim_dn) begin
            if (state_q != '0) state_d = state_q - ST_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
         lfsr_q  <= SEED;
      end else if (step) begin
         state_q <= state_d;
         lfsr_q  <= {lfsr_q[PROB_W-2:0], fb};
      end
   end

   assign state = state_q;

   p_state_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(state));
   p_state_step_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (state == $past(state) || state == $past(state) + ST_W'(1)
                || state == $past(state) - ST_W'(1)));
   p_state_max_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      state <= TOP);
endmodule

// File: rtl/ojit_cell_fifo.sv
module ojit_cell_fifo
   import ojit_pkg::*;
#(
   parameter int CELLS = 8,
   localparam int PW   = $clog2(CELLS),
   localparam int CW   = $clog2(CELLS + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_pos,
   input  logic [7:0]       wr_data,
   input  logic             push,
   input  logic             pop,
   input  logic [IDX_W-1:0] rd_pos,
   output logic [7:0]       rd_data,
   output logic [CW-1:0]    count
);
   logic [7:0]    mem [CELLS][CELL_BYTES];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt_q;

   initial begin : g_param_chk
      assert (CELLS == (1 << PW)) else $error("CELLS must be a power of two");
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr][wr_pos] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PW'(1);
         if (pop)  rd_ptr <= rd_ptr + PW'(1);
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign rd_data = mem[rd_ptr][rd_pos];
   assign count   = cnt_q;

   p_no_overflow_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CW'(CELLS) || pop));
   p_no_underflow_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> count != '0);
endmodule

// File: rtl/ordered_jitter.sv
module ordered_jitter
   import ojit_pkg::*;
#(
   parameter int                MAX_STATE   = 6,
   parameter int                SLOT_DEPTH  = 8,
   parameter int                MATCH_CELLS = 8,
   parameter int                PLAIN_CELLS = 16,
   parameter int                PROB_W      = 16,
   parameter logic [PROB_W-1:0] SEED        = 'hACE1,
   localparam int               ST_W        = $clog2(MAX_STATE + 1),
   localparam int               SL_W        = $clog2(SLOT_DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        in_data,
   input  logic              in_start,
   input  logic              in_empty,
   input  logic              flt_all,
   input  logic [7:0]        flt_vpi,
   input  logic [7:0]        flt_vpi_mask,
   input  logic [15:0]       flt_vci,
   input  logic [15:0]       flt_vci_mask,
   input  logic              tbl_we,
   input  logic [ST_W-1:0]   tbl_idx,
   input  logic [PROB_W-1:0] tbl_up,
   input  logic [PROB_W-1:0] tbl_dn,
   output logic [7:0]        out_data,
   output logic              out_start,
   output logic              out_empty
);
   localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(CELL_BYTES - 1);
   localparam int MCW = $clog2(MATCH_CELLS + 1);
   localparam int PCW = $clog2(PLAIN_CELLS + 1);

   initial begin : g_param_chk
      assert (SLOT_DEPTH == (1 << SL_W)) else $error("SLOT_DEPTH must be a power of two");
      assert (MAX_STATE < SLOT_DEPTH) else $error("MAX_STATE must be below SLOT_DEPTH");
      assert (MATCH_CELLS >= MAX_STATE + 2) else $error("MATCH_CELLS too small");
   end

   // byte position tracking
   logic             run_q, active, first_byte, commit;
   logic [IDX_W-1:0] pos_q, pos;

   assign pos        = in_start ? '0 : pos_q;
   assign active     = in_start | run_q;
   assign first_byte = active && pos == '0;
   assign commit     = active && pos == LAST_POS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         pos_q <= '0;
      end else if (active) begin
         run_q <= 1'b1;
         pos_q <= (pos == LAST_POS) ? '0 : pos + IDX_W'(1);
      end
   end

   // filter
   logic     hit, is_void;
   vc_addr_t want, care;
   assign want = '{vpi: flt_vpi, vci: flt_vci};
   assign care = '{vpi: flt_vpi_mask, vci: flt_vci_mask};

   ojit_hdr_filter u_filter (
      .clk(clk), .rst_n(rst_n), .en(active), .pos(pos), .data(in_data),
      .void_in(in_empty), .last(commit), .sel_all(flt_all),
      .want(want), .care(care), .hit(hit), .is_void(is_void)
   );

   // Markov chain
   logic [ST_W-1:0] state;
   logic            step;
   assign step = commit && !hit;

   ojit_chain #(.MAX_STATE(MAX_STATE), .PROB_W(PROB_W), .SEED(SEED)) u_chain (
      .clk(clk), .rst_n(rst_n), .step(step), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
      .tbl_up(tbl_up), .tbl_dn(tbl_dn), .state(state)
   );

   // cell stores
   logic           m_push, m_pop, p_push, p_pop;
   logic [7:0]     m_byte, p_byte;
   logic [MCW-1:0] m_cnt;
   logic [PCW-1:0] p_cnt;

   assign m_push = commit && hit;
   assign p_push = commit && !hit && !is_void;

   ojit_cell_fifo #(.CELLS(MATCH_CELLS)) u_match_q (
      .clk(clk), .rst_n(rst_n), .wr_en(active), .wr_pos(pos), .wr_data(in_data),
      .push(m_push), .pop(m_pop), .rd_pos(pos), .rd_data(m_byte), .count(m_cnt)
   );

   ojit_cell_fifo #(.CELLS(PLAIN_CELLS)) u_plain_q (
      .clk(clk), .rst_n(rst_n), .wr_en(active), .wr_pos(pos), .wr_data(in_data),
      .push(p_push), .pop(p_pop), .rd_pos(pos), .rd_data(p_byte), .count(p_cnt)
   );

   // slot scheduler
   logic [SLOT_DEPTH-1:0] ctl_q;
   logic [SL_W-1:0]       islot_q, rd_slot, tgt;
   logic                  orun_q;
   src_e                  sel_q, sel_cur;

   assign rd_slot = islot_q - SL_W'(1);
   assign tgt     = islot_q + SL_W'(state);

   always_comb begin
      sel_cur = sel_q;
      if (!orun_q) begin
         sel_cur = SRC_IDLE;
      end else if (first_byte) begin
         if (ctl_q[rd_slot])     sel_cur = SRC_MATCH;
         else if (p_cnt != '0)   sel_cur = SRC_PLAIN;
         else                    sel_cur = SRC_IDLE;
      end
   end

   assign m_pop = commit && orun_q && sel_cur == SRC_MATCH;
   assign p_pop = commit && orun_q && sel_cur == SRC_PLAIN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         islot_q <= '0;
         orun_q  <= 1'b0;
         sel_q   <= SRC_IDLE;
      end else begin
         if (active) sel_q <= sel_cur;
         if (commit) begin
            islot_q <= islot_q + SL_W'(1);
            orun_q  <= 1'b1;
         end
         if (commit && orun_q) ctl_q[rd_slot] <= 1'b0;
         if (m_push)           ctl_q[tgt]     <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data  <= '0;
         out_start <= 1'b0;
         out_empty <= 1'b1;
      end else begin
         out_start <= first_byte && orun_q;
         out_empty <= !(active && orun_q) || sel_cur == SRC_IDLE;
         if (active && orun_q && sel_cur == SRC_MATCH)      out_data <= m_byte;
         else if (active && orun_q && sel_cur == SRC_PLAIN) out_data <= p_byte;
         else                                               out_data <= '0;
      end
   end

   p_match_ready_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (first_byte && orun_q && ctl_q[rd_slot]) |-> m_cnt != '0);
   p_slot_free_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (m_push && !(orun_q && tgt == rd_slot)) |-> !ctl_q[tgt]);
   p_start_gap_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      out_start |=> !out_start);
   p_idle_zero_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_empty && orun_q) |-> out_data == '0);
endmodule

// File: tb/ordered_jitter_tb.sv
module ordered_jitter_tb;
   localparam int MAXS = 6;
   localparam int NC   = 560;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_start = 1'b0, in_empty = 1'b0;
   logic        flt_all = 1'b0;
   logic [7:0]  flt_vpi = 8'h5A, flt_vpi_mask = 8'hFF;
   logic [15:0] flt_vci = 16'h1234, flt_vci_mask = 16'hFFF0;
   logic        tbl_we = 1'b0;
   logic [2:0]  tbl_idx = '0;
   logic [15:0] tbl_up = '0, tbl_dn = '0;
   logic [7:0]  out_data;
   logic        out_start, out_empty;

   always #2 clk = ~clk;

   ordered_jitter u_dut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_start(in_start), .in_empty(in_empty),
      .flt_all(flt_all), .flt_vpi(flt_vpi), .flt_vpi_mask(flt_vpi_mask),
      .flt_vci(flt_vci), .flt_vci_mask(flt_vci_mask), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
      .tbl_up(tbl_up), .tbl_dn(tbl_dn), .out_data(out_data), .out_start(out_start),
      .out_empty(out_empty)
   );

   int n_checks = 0, n_fail = 0;
   bit done = 0;
   logic [7:0] cmem [NC][53];
   bit         cvoid [NC];
   int         arr_slot [NC];
   int         due [int];
   int         pq [$];
   int         mst = 0;
   logic [15:0] mlf = 16'hACE1;
   logic [15:0] mup [MAXS+1];
   logic [15:0] mdn [MAXS+1];
   logic [31:0] rs = 32'h1357_9BDF;
   int sent = 0, got = 0, cur_eid = -1;
   string cur_tag = "R8";

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int rnd100();
      rs = rs * 32'd1103515245 + 32'd12345;
      return int'(rs[30:16]) % 100;
   endfunction

   function automatic bit picked(bit v, logic [7:0] vp, logic [15:0] vc);
      if (v) return 0;
      return flt_all || ((((vp ^ flt_vpi) & flt_vpi_mask) == 0) &&
                         (((vc ^ flt_vci) & flt_vci_mask) == 0));
   endfunction

   task automatic build(input int t, input int phase);
      int r;
      logic [7:0] vp;
      logic [15:0] vc;
      r = (phase == 4) ? 0 : rnd100();
      cvoid[t] = (r < 38);
      vp = 8'h5A;
      vc = 16'h1230 | 16'(rnd100() % 16);
      if (!cvoid[t] && r >= 68) begin
         if (r % 2 == 0) vp = 8'h5B;
         else vc = 16'h2234;
      end
      for (int k = 0; k < 53; k++) cmem[t][k] = 8'(t * 7 + k);
      cmem[t][0] = {4'h0, vp[7:4]};
      cmem[t][1] = {vp[3:0], vc[15:12]};
      cmem[t][2] = vc[11:4];
      cmem[t][3] = {vc[3:0], 4'h0};
      cmem[t][4] = 8'(t);
      if (cvoid[t]) for (int k = 0; k < 53; k++) cmem[t][k] = '0;
   endtask

   task automatic model_commit(input int t);
      logic [16:0] r, u, s;
      if (picked(cvoid[t], {cmem[t][0][3:0], cmem[t][1][7:4]},
                 {cmem[t][1][3:0], cmem[t][2], cmem[t][3][7:4]})) begin
         due[t + mst] = t;
      end else begin
         r = {1'b0, mlf};
         u = {1'b0, mup[mst]};
         s = u + {1'b0, mdn[mst]};
         if (r < u) begin if (mst < MAXS) mst++; end
         else if (r < s) begin if (mst > 0) mst--; end
         mlf = {mlf[14:0], mlf[15] ^ mlf[13] ^ mlf[12] ^ mlf[10]};
         if (!cvoid[t]) pq.push_back(t);
      end
      arr_slot[t] = t;
      if (!cvoid[t]) sent++;
   endtask

   task automatic run_cell(input int t, input int phase);
      build(t, phase);
      for (int k = 0; k < 53; k++) begin
         in_data  = cmem[t][k];
         in_start = (k == 0);
         in_empty = cvoid[t];
         tbl_we   = 1'b0;
         if (t == 60 && k <= MAXS) begin
            tbl_we  = 1'b1;
            tbl_idx = 3'(k);
            tbl_up  = (k == 0) ? 16'h3000 : (k == MAXS) ? 16'hC000 : 16'h5800;
            tbl_dn  = (k == 0) ? 16'h9000 : (k == MAXS) ? 16'h3000 : 16'h5000;
            mup[k]  = tbl_up;
            mdn[k]  = tbl_dn;
         end
         @(posedge clk);
         #1;
         if (t == 0) begin
            chk(out_start == 0 && out_empty == 1 && out_data == 0, "R1",
                {out_start, out_empty, out_data}, 10'h100);
         end else begin
            if (k == 0) begin
               chk(out_start == 1, "R2", out_start, 1);
               if (due.exists(t - 1)) begin
                  cur_eid = due[t - 1];
                  due.delete(t - 1);
                  cur_tag = (phase == 1) ? "R5" : (phase >= 2) ? "R3" : "R4";
               end else if (pq.size() > 0) begin
                  cur_eid = pq.pop_front();
                  cur_tag = (arr_slot[cur_eid] < t - 1) ? "R7" : "R6";
               end else begin
                  cur_eid = -1;
                  cur_tag = "R8";
               end
               if (!out_empty) got++;
            end else begin
               chk(out_start == 0, "R2", out_start, 0);
            end
            if (cur_eid < 0)
               chk(out_empty == 1 && out_data == 0, cur_tag, {out_empty, out_data}, 9'h100);
            else
               chk(out_empty == 0 && out_data == cmem[cur_eid][k], cur_tag,
                   {out_empty, out_data}, {1'b0, cmem[cur_eid][k]});
         end
         if (k == 52) model_commit(t);
         @(negedge clk);
      end
   endtask

   initial begin
      for (int i = 0; i <= MAXS; i++) begin mup[i] = '0; mdn[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #1;
         chk(out_start == 0 && out_empty == 1 && out_data == 0, "R1",
             {out_start, out_empty, out_data}, 10'h100);
         @(negedge clk);
      end
      for (int t = 0; t < NC; t++) begin
         int ph;
         ph = (t < 60) ? 0 : (t < 300) ? 1 : (t < 420) ? 2 : (t < 520) ? 3 : 4;
         if (t == 300) flt_all = 1'b1;
         if (t == 420) begin flt_all = 1'b0; flt_vci_mask = 16'h0000; end
         run_cell(t, ph);
      end
      chk(got == sent, "R9", got, sent);
      chk(due.size() == 0 && pq.size() == 0, "R9", due.size() + pq.size(), 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R2 act=hung exp=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule